// File: doc/BRIEF.md
# Display Serial Command/Data Serializer

This block takes bytes from a host over a valid/ready handshake and shifts them out on a write-only serial link to a small colour display controller. Each byte arrives with a flag that marks it as a command (flag 0) or as pixel/parameter data (flag 1). The block drives the serial clock, the serial data line, an active-low select, a command/data line and an active-low reset for the display.

The `mode_3w` input picks the framing, and the block samples it when it accepts a byte. With `mode_3w` high, the flag rides inside the frame as a leading ninth bit, and the command/data line is not used. With `mode_3w` low, a frame carries the eight payload bits only, and the command/data line gives the flag. Bytes that arrive while a frame is ending are sent back to back under one select window. A one-cycle reset request pulls the display reset low for a fixed number of clocks.

The control is a single state machine with six states. IDLE: select high, waiting. RST_HOLD: display reset held low. LEAD: select low, first bit presented, clock low. SCK_HI: clock high. SCK_LO: clock low with the next bit presented. GAP: a single cycle after the last high phase of a frame. The transitions are as follows. IDLE goes to RST_HOLD on a reset request and to LEAD on an accepted byte. RST_HOLD goes to IDLE when the pulse ends. LEAD goes to SCK_HI after one half-period. SCK_HI goes to SCK_LO after one half-period while bits remain, and to GAP after the last bit. SCK_LO goes to SCK_HI after one half-period. GAP goes to SCK_LO when a byte is waiting, and to IDLE otherwise.

Top module: `dsp_ser`

## Requirements
- R1: With `mode_3w` high, a frame is 9 bits on `sdo`, sampled at rising `sck` edges. The first bit is the flag (0 command, 1 data), followed by the payload with bit 7 first.
- R2: With `mode_3w` low, a frame is 8 payload bits with bit 7 first. `dc` equals the byte's flag (0 command, 1 data) from before the first rising edge through the last rising edge of that byte.
- R3: With `mode_3w` high, `dc` stays at 0 for the whole frame.
- R4: `sck` idles low and is high only while `cs_n` is low. `sdo` changes only while `sck` is low and is stable across every high phase.
- R5: Every high phase and every low phase inside a frame lasts HALF_DIV clocks, with values below 2 raised to 2. `cs_n` falls HALF_DIV clocks before the first rising edge.
- R6: `in_ready` is low from the cycle after a byte is accepted until the last high phase of its frame has ended.
- R7: If `in_valid` is high when a frame ends, the next byte is taken in the GAP cycle. `cs_n` stays low and the next frame follows.
- R8: With nothing queued, `cs_n` returns high after the last high phase, so there is exactly one `cs_n` rise per frame.
- R9: A `rst_req` pulse in IDLE drives `lcd_rst_n` low for exactly RST_CYCLES clocks. `rst_req` takes priority over `in_valid` in the same cycle. While `lcd_rst_n` is low, `in_ready` is low, `cs_n` is high and `sck` does not toggle. A byte held waiting is sent afterwards.
- R10: After `rst_n`, `cs_n`=1, `sck`=0, `dc`=0, `lcd_rst_n`=1 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| mode_3w | input | 1 | 1: 9-bit frames with embedded flag; 0: 8-bit frames plus `dc` |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Payload byte |
| in_is_data | input | 1 | Flag: 0 command, 1 data |
| rst_req | input | 1 | Request a display reset pulse |
| sck | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data |
| cs_n | output | 1 | Active-low select |
| dc | output | 1 | Command/data line (0 command, 1 data) |
| lcd_rst_n | output | 1 | Active-low display reset |

## Verification
The bench builds the block with HALF_DIV=3 and RST_CYCLES=6. A half-period of three clocks makes an off-by-one in the divider or in the LEAD state show up as a measured length of 2 or 4. A reset of six clocks is short enough to count exactly and long enough to show that a byte held waiting is not taken early. Because `mode_3w` is an input, one build covers both framings, including a back-to-back pair in which the flag changes between bytes.

// File: rtl/dsp_ser_pkg.sv
package dsp_ser_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_HOLD,
        ST_LEAD,
        ST_SCK_HI,
        ST_SCK_LO,
        ST_GAP
    } ser_state_e;

    localparam int FRAME_MAX = 9;
    localparam int FRAME_4W  = 8;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);

endpackage

// File: rtl/dsp_ser_tick.sv
module dsp_ser_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int HD = (HALF_DIV < 2) ? 2 : HALF_DIV;
    localparam int CW = $clog2(HD);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(HD - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dsp_ser_rstgen.sv
module dsp_ser_rstgen #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic lcd_rst_n
);
    localparam int RC = (RST_CYCLES < 1) ? 1 : RST_CYCLES;
    localparam int CW = $clog2(RC + 1);

    logic [CW-1:0] left_q;

    assign busy      = (left_q != '0);
    assign lcd_rst_n = !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= CW'(RC);
        end else if (busy) begin
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/dsp_ser_shift.sv
module dsp_ser_shift
    import dsp_ser_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       mode_3w,
    input  logic       is_data,
    input  logic [7:0] data,
    input  logic       shift,
    output logic       msb,
    output logic       last
);
    logic [FRAME_MAX-1:0] sreg_q;
    logic [CNT_W-1:0]     left_q;

    assign msb  = sreg_q[FRAME_MAX-1];
    assign last = (left_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            left_q <= '0;
        end else if (load) begin
            sreg_q <= mode_3w ? {is_data, data} : {data, 1'b0};
            left_q <= mode_3w ? CNT_W'(FRAME_MAX) : CNT_W'(FRAME_4W);
        end else if (shift) begin
            sreg_q <= {sreg_q[FRAME_MAX-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/dsp_ser.sv
module dsp_ser
    import dsp_ser_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_3w,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_is_data,
    input  logic       rst_req,
    output logic       sck,
    output logic       sdo,
    output logic       cs_n,
    output logic       dc,
    output logic       lcd_rst_n
);
    ser_state_e state_q, state_d;

    logic tick, tick_clear;
    logic rst_start, rst_busy;
    logic load, shift_en, bit_msb, bit_last;
    logic dc_q;
    logic accept;

    dsp_ser_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tick_clear),
        .tick  (tick)
    );

    dsp_ser_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rstgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rst_start),
        .busy      (rst_busy),
        .lcd_rst_n (lcd_rst_n)
    );

    dsp_ser_shift u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .mode_3w (mode_3w),
        .is_data (in_is_data),
        .data    (in_data),
        .shift   (shift_en),
        .msb     (bit_msb),
        .last    (bit_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rst_req) begin
                    state_d = ST_RST_HOLD;
                end else if (in_valid) begin
                    state_d = ST_LEAD;
                end
            end
            ST_RST_HOLD: begin
                if (!rst_busy) state_d = ST_IDLE;
            end
            ST_LEAD: begin
                if (tick) state_d = ST_SCK_HI;
            end
            ST_SCK_HI: begin
                if (tick) state_d = bit_last ? ST_GAP : ST_SCK_LO;
            end
            ST_SCK_LO: begin
                if (tick) state_d = ST_SCK_HI;
            end
            ST_GAP: begin
                state_d = in_valid ? ST_SCK_LO : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output and control decode
    always_comb begin
        in_ready   = 1'b0;
        sck        = 1'b0;
        cs_n       = 1'b0;
        rst_start  = 1'b0;
        tick_clear = 1'b0;
        shift_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready   = !rst_req;
                cs_n       = 1'b1;
                rst_start  = rst_req;
                tick_clear = 1'b1;
            end
            ST_RST_HOLD: begin
                cs_n       = 1'b1;
                tick_clear = 1'b1;
            end
            ST_LEAD: begin
            end
            ST_SCK_HI: begin
                sck      = 1'b1;
                shift_en = tick && !bit_last;
            end
            ST_SCK_LO: begin
            end
            ST_GAP: begin
                in_ready   = 1'b1;
                tick_clear = 1'b1;
            end
            default: begin
                cs_n = 1'b1;
            end
        endcase
    end

    assign accept = in_valid && in_ready;
    assign load   = accept;
    assign sdo    = cs_n ? 1'b0 : bit_msb;
    assign dc     = dc_q;

    // Command/data line: updated only when a byte is taken
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dc_q <= 1'b0;
        end else if (accept) begin
            dc_q <= mode_3w ? 1'b0 : in_is_data;
        end
    end
endmodule

// File: rtl/dsp_ser_chk.sv
module dsp_ser_chk (
    input logic clk,
    input logic rst_n,
    input logic sck,
    input logic sdo,
    input logic cs_n,
    input logic dc,
    input logic in_ready,
    input logic lcd_rst_n
);
    p_sdo_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(sdo));

    p_sck_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);

    p_dc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(dc));

    p_busy_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !in_ready);

    p_reset_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n |-> (!in_ready && cs_n && !sck));

    p_select_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !sck);
endmodule

bind dsp_ser dsp_ser_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck       (sck),
    .sdo       (sdo),
    .cs_n      (cs_n),
    .dc        (dc),
    .in_ready  (in_ready),
    .lcd_rst_n (lcd_rst_n)
);

// File: tb/dsp_ser_bench.sv
module dsp_ser_bench;
    localparam int HD = 3;
    localparam int RC = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_3w = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_is_data = 1'b0;
    logic       rst_req = 1'b0;
    logic       sck, sdo, cs_n, dc, lcd_rst_n;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dsp_ser #(.HALF_DIV(HD), .RST_CYCLES(RC)) u_dsp_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_3w    (mode_3w),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_is_data (in_is_data),
        .rst_req    (rst_req),
        .sck        (sck),
        .sdo        (sdo),
        .cs_n       (cs_n),
        .dc         (dc),
        .lcd_rst_n  (lcd_rst_n)
    );

    // Line monitor, sampled on the falling clock edge
    logic        mon_clr = 1'b0;
    logic        prev_sck = 1'b0;
    logic        prev_cs = 1'b1;
    logic        sdo_at_rise = 1'b0;
    logic [31:0] cap = '0;
    logic [31:0] dcv = '0;
    int ncap, hi_run, hi_min, hi_max, lo_run, lo_bad, lead_rec;
    int sdo_bad, rdy_bad, cs_rise, rst_low, rst_rdy, rst_sck;

    always @(negedge clk) begin
        if (mon_clr) begin
            cap = '0; dcv = '0; ncap = 0; hi_run = 0; hi_min = 1000; hi_max = 0;
            lo_run = 0; lo_bad = 0; lead_rec = -1; sdo_bad = 0; rdy_bad = 0;
            cs_rise = 0; rst_low = 0; rst_rdy = 0; rst_sck = 0;
        end else begin
            if (sck && !prev_sck) begin
                cap = {cap[30:0], sdo};
                dcv = {dcv[30:0], dc};
                if (ncap == 0) lead_rec = lo_run;
                else if (lo_run != HD) lo_bad++;
                ncap++;
                sdo_at_rise = sdo;
                lo_run = 0;
                hi_run = 1;
            end else if (sck) begin
                hi_run++;
                if (sdo != sdo_at_rise) sdo_bad++;
            end
            if (!sck && prev_sck) begin
                if (hi_run < hi_min) hi_min = hi_run;
                if (hi_run > hi_max) hi_max = hi_run;
            end
            if (!cs_n && !sck) lo_run++;
            if (cs_n) lo_run = 0;
            if (cs_n && !prev_cs) cs_rise++;
            if (sck && in_ready) rdy_bad++;
            if (!lcd_rst_n) begin
                rst_low++;
                if (in_ready) rst_rdy++;
                if (sck || !cs_n) rst_sck++;
            end
        end
        prev_sck = sck;
        prev_cs  = cs_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk); mon_clr = 1'b1;
        @(posedge clk); mon_clr = 1'b0;
    endtask

    task automatic send_byte(input logic flag, input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_is_data = flag; in_data = b;
        forever begin
            if (in_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R6 ready after accept", int'(in_ready), 0);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(cs_n && in_ready)) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_timing(input string tag);
        chk(sdo_bad == 0, {"R4 sdo stable ", tag}, sdo_bad, 0);
        chk(hi_min == HD && hi_max == HD, {"R5 high phase ", tag}, hi_max, HD);
        chk(lead_rec == HD, {"R5 select lead ", tag}, lead_rec, HD);
        chk(rdy_bad == 0, {"R6 ready in frame ", tag}, rdy_bad, 0);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(cs_n == 1'b1 && sck == 1'b0, "R10 select/clock idle", {cs_n, sck}, 2'b10);
        chk(lcd_rst_n == 1'b1 && dc == 1'b0, "R10 reset/dc idle", {lcd_rst_n, dc}, 2'b10);
        chk(in_ready == 1'b1, "R10 ready idle", int'(in_ready), 1);
    endtask

    task automatic t_three_wire(input logic flag, input logic [7:0] b);
        mode_3w = 1'b1;
        clear_mon();
        send_byte(flag, b);
        wait_idle();
        chk(ncap == 9, "R1 bit count", ncap, 9);
        chk(cap[8:0] == {flag, b}, "R1 frame bits", int'(cap[8:0]), int'({flag, b}));
        chk(dcv[8:0] == 9'h000 && dc == 1'b0, "R3 dc held low", int'(dcv[8:0]), 0);
        chk(lo_bad == 0, "R5 low phase", lo_bad, 0);
        chk(cs_rise == 1, "R8 select release", cs_rise, 1);
        check_timing("3w");
    endtask

    task automatic t_four_wire(input logic flag, input logic [7:0] b);
        mode_3w = 1'b0;
        clear_mon();
        send_byte(flag, b);
        wait_idle();
        chk(ncap == 8, "R2 bit count", ncap, 8);
        chk(cap[7:0] == b, "R2 payload bits", int'(cap[7:0]), int'(b));
        chk(dcv[7:0] == {8{flag}}, "R2 dc flag", int'(dcv[7:0]), int'({8{flag}}));
        chk(lo_bad == 0, "R5 low phase", lo_bad, 0);
        chk(cs_rise == 1, "R8 select release", cs_rise, 1);
        check_timing("4w");
    endtask

    task automatic t_back_to_back();
        mode_3w = 1'b0;
        clear_mon();
        send_byte(1'b0, 8'h81);
        send_byte(1'b1, 8'h7E);
        wait_idle();
        chk(ncap == 16, "R7 pair bit count", ncap, 16);
        chk(cap[15:0] == 16'h817E, "R7 pair bits", int'(cap[15:0]), 16'h817E);
        chk(dcv[15:0] == 16'h00FF, "R2 dc per byte", int'(dcv[15:0]), 16'h00FF);
        chk(cs_rise == 1, "R7 select held", cs_rise, 1);
        check_timing("pair");
    endtask

    task automatic t_display_reset();
        mode_3w = 1'b0;
        clear_mon();
        @(negedge clk);
        rst_req = 1'b1; in_valid = 1'b1; in_is_data = 1'b0; in_data = 8'hC3;
        @(negedge clk);
        rst_req = 1'b0;
        forever begin
            if (in_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        wait_idle();
        chk(rst_low == RC, "R9 reset width", rst_low, RC);
        chk(rst_rdy == 0, "R9 ready during reset", rst_rdy, 0);
        chk(rst_sck == 0, "R9 link quiet during reset", rst_sck, 0);
        chk(ncap == 8 && cap[7:0] == 8'hC3, "R9 waiting byte sent", int'(cap[7:0]), 8'hC3);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset_state();
        t_three_wire(1'b0, 8'hA5);
        t_three_wire(1'b1, 8'h01);
        t_four_wire(1'b0, 8'h80);
        t_four_wire(1'b1, 8'h3C);
        t_back_to_back();
        t_display_reset();
        t_three_wire(1'b1, 8'hFE);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule